// File: doc/BRIEF.md
# NAND Command Cycle Sequencer

This block turns one host command request into the cycle sequence an 8-bit NAND flash device expects. The host presents an opcode with a column and a page address. The block looks the opcode up in a built-in format table. The table gives the opcode's address cycle count, its optional closing opcode, whether that closing opcode goes out at once or waits until after the data phase, and whether the device must be polled for ready afterwards. The block then drives the command latch, address latch and write strobe to place each byte on the bus.

A closing opcode that belongs to the data phase is not sent. It is remembered as pending instead. When the host later issues a request carrying that same opcode, the request is absorbed: it is acknowledged without touching the bus, and the pending record is cleared. Some commands hold off the acknowledge until the ready/busy line shows ready. A programmable cycle limit turns a stuck busy line into an error acknowledge, so the block does not hang. Opcodes missing from the table are acknowledged with an error flag, and nothing goes out on the bus.

For devices whose page is larger than 512 bytes, a spare-area read request (0x50) is turned into a page read. Its column is advanced by the page size.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset the bus is idle: nand_we_n=1, nand_cle=0, nand_ale=0, nand_io_oe=0 and req_ack=0.
- R2: Every bus byte holds nand_we_n low for exactly one clock and then high for one clock. The byte on nand_io_out and the latch lines stay stable across both clocks. Opcode bytes have nand_cle=1 and nand_ale=0. Address bytes have nand_ale=1 and nand_cle=0. The two latch lines are never high together.
- R3: Opcode 0x00 sends 0x00, then five address bytes, then 0x30, and then waits for ready. The address bytes are column bits [7:0], column bits [15:8], then page bits [7:0], [15:8] and [23:16], least significant first.
- R4: Opcode 0x05 sends 0x05, then column bytes [7:0] and [15:8], then 0xE0. It does not wait for ready.
- R5: Opcodes 0x90, 0xEC, 0xEE and 0xEF each send the opcode followed by a single address byte, column bits [7:0]. None sends a second opcode. 0xEC and 0xEE wait for ready; 0x90 and 0xEF do not.
- R6: Opcodes 0x70 and 0xFF send only the opcode byte. 0xFF waits for ready; 0x70 does not.
- R7: Opcode 0x60 sends 0x60, then page bytes [7:0], [15:8] and [23:16], then 0xD0. It does not wait for ready.
- R8: Opcode 0x80 sends 0x80 and the same five address bytes as R3, with no second opcode, and records 0x10 as pending. Opcode 0x85 sends 0x85 and the two column bytes only.
- R9: A request whose opcode equals the pending opcode is acknowledged with both error flags low and no bus byte, and the pending record clears. A repeat of 0x10 after that is an unknown opcode.
- R10: An opcode not in the table is acknowledged with ack_err_unknown=1 and no bus byte.
- R11: req_ack is a single-cycle pulse. For a command that waits for ready, it is not raised before nand_rb=1 has been sampled, unless the wait times out.
- R12: If nand_rb stays 0 for tmo_limit consecutive clocks while waiting, the request is acknowledged with ack_err_timeout=1.
- R13: With PAGE_BYTES above 512, opcode 0x50 produces the R3 sequence starting with 0x00, with the column replaced by column+PAGE_BYTES (modulo 2^16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; held until req_ack |
| req_op | input | 8 | Requested opcode |
| req_col | input | 16 | Column address |
| req_page | input | 24 | Page address |
| tmo_limit | input | 16 | Ready-wait limit in clocks |
| req_ack | output | 1 | Request complete (one-cycle pulse) |
| ack_err_unknown | output | 1 | With req_ack: opcode not in table |
| ack_err_timeout | output | 1 | With req_ack: ready wait expired |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_io_out | output | 8 | Byte driven to the device |
| nand_io_oe | output | 1 | Output enable for nand_io_out |
| nand_rb | input | 1 | Ready/busy, 1 = ready |

## Verification
Some properties are checked by assertions on every cycle. The latch lines are mutually exclusive. Each write strobe is one clock wide, and the byte and latch lines stay stable through the pulse. The acknowledge is a single-cycle pulse. The sequencer stays in its wait while busy persists below the limit. An absorbed pending opcode or an unknown opcode is acknowledged on the next cycle with the bus silent. Other behaviour needs the bench's scenarios: the exact byte order and latch type of each opcode's sequence, the column remap for spare-area reads, the pending record surviving unrelated commands, and the timeout error under a busy line that never releases.

// File: rtl/nand_seq_pkg.sv
// Shared opcode constants, format record and state encoding for the
// NAND command sequencer. Assumes an 8-bit device bus.
package nand_seq_pkg;

    localparam logic [7:0] OPC_READ    = 8'h00;
    localparam logic [7:0] OPC_READ2   = 8'h30;
    localparam logic [7:0] OPC_RDOUT   = 8'h05;
    localparam logic [7:0] OPC_RDOUT2  = 8'hE0;
    localparam logic [7:0] OPC_ID      = 8'h90;
    localparam logic [7:0] OPC_STAT    = 8'h70;
    localparam logic [7:0] OPC_PROG    = 8'h80;
    localparam logic [7:0] OPC_PROG2   = 8'h10;
    localparam logic [7:0] OPC_WRIN    = 8'h85;
    localparam logic [7:0] OPC_ERASE   = 8'h60;
    localparam logic [7:0] OPC_ERASE2  = 8'hD0;
    localparam logic [7:0] OPC_RST     = 8'hFF;
    localparam logic [7:0] OPC_PARAM   = 8'hEC;
    localparam logic [7:0] OPC_GETF    = 8'hEE;
    localparam logic [7:0] OPC_SETF    = 8'hEF;
    localparam logic [7:0] OPC_SPARE   = 8'h50;

    // One format table entry
    typedef struct packed {
        logic       known;    // opcode present in table
        logic [7:0] op1;      // opcode sent first
        logic       has2;     // a closing opcode exists
        logic [7:0] op2;      // closing opcode
        logic       defer;    // closing opcode waits for data phase
        logic [2:0] ncol;     // column address bytes
        logic [2:0] npage;    // page address bytes
        logic       wait_rb;  // poll ready/busy before ack
    } nfmt_t;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_CMD1, SQ_ADDR, SQ_CMD2, SQ_WAIT, SQ_ACK
    } seq_state_t;

endpackage

// File: rtl/nand_fmt_rom.sv
// Opcode format lookup. Purely combinational. Maps a spare-area read
// to a page read with an offset column when the page exceeds 512 bytes.
module nand_fmt_rom
    import nand_seq_pkg::*;
#(
    parameter int COL_W      = 16,
    parameter int PAGE_BYTES = 2048
) (
    input  logic [7:0]       op,
    input  logic [COL_W-1:0] col,
    output nfmt_t            fmt,
    output logic [COL_W-1:0] col_eff
);
    localparam logic SPARE_REMAP = (PAGE_BYTES > 512);
    localparam logic [COL_W-1:0] COL_OFS = COL_W'(PAGE_BYTES);

    // Build a table entry
    function automatic nfmt_t mk(input logic [7:0] a, input logic h,
                                 input logic [7:0] b, input logic d,
                                 input logic [2:0] nc, input logic [2:0] np,
                                 input logic w);
        nfmt_t f;
        f.known = 1'b1; f.op1 = a; f.has2 = h; f.op2 = b; f.defer = d;
        f.ncol = nc; f.npage = np; f.wait_rb = w;
        return f;
    endfunction

    // Table lookup per opcode
    always_comb begin
        fmt     = '0;
        col_eff = col;
        case (op)
            OPC_READ:  fmt = mk(OPC_READ,  1'b1, OPC_READ2,  1'b0, 3'd2, 3'd3, 1'b1);
            OPC_RDOUT: fmt = mk(OPC_RDOUT, 1'b1, OPC_RDOUT2, 1'b0, 3'd2, 3'd0, 1'b0);
            OPC_ID:    fmt = mk(OPC_ID,    1'b0, 8'h00,      1'b0, 3'd1, 3'd0, 1'b0);
            OPC_STAT:  fmt = mk(OPC_STAT,  1'b0, 8'h00,      1'b0, 3'd0, 3'd0, 1'b0);
            OPC_PROG:  fmt = mk(OPC_PROG,  1'b1, OPC_PROG2,  1'b1, 3'd2, 3'd3, 1'b0);
            OPC_WRIN:  fmt = mk(OPC_WRIN,  1'b0, 8'h00,      1'b0, 3'd2, 3'd0, 1'b0);
            OPC_ERASE: fmt = mk(OPC_ERASE, 1'b1, OPC_ERASE2, 1'b0, 3'd0, 3'd3, 1'b0);
            OPC_RST:   fmt = mk(OPC_RST,   1'b0, 8'h00,      1'b0, 3'd0, 3'd0, 1'b1);
            OPC_PARAM: fmt = mk(OPC_PARAM, 1'b0, 8'h00,      1'b0, 3'd1, 3'd0, 1'b1);
            OPC_GETF:  fmt = mk(OPC_GETF,  1'b0, 8'h00,      1'b0, 3'd1, 3'd0, 1'b1);
            OPC_SETF:  fmt = mk(OPC_SETF,  1'b0, 8'h00,      1'b0, 3'd1, 3'd0, 1'b0);
            OPC_SPARE: begin
                if (SPARE_REMAP) begin
                    fmt     = mk(OPC_READ, 1'b1, OPC_READ2, 1'b0, 3'd2, 3'd3, 1'b1);
                    col_eff = col + COL_OFS;
                end
            end
            default: fmt = '0;
        endcase
    end
endmodule

// File: rtl/nand_addr_mux.sv
// Selects the address byte for a given address cycle index: column
// bytes first, then page bytes, least significant first.
// Assumes ncol <= COL_W/8 and the page byte count <= PAGE_W/8.
module nand_addr_mux #(
    parameter int COL_W  = 16,
    parameter int PAGE_W = 24
) (
    input  logic [2:0]        idx,
    input  logic [2:0]        ncol,
    input  logic [COL_W-1:0]  col,
    input  logic [PAGE_W-1:0] page,
    output logic [7:0]        abyte
);
    localparam int NCB = COL_W / 8;
    localparam int NPB = PAGE_W / 8;

    logic [7:0] cb [NCB];
    logic [7:0] pb [NPB];
    logic [2:0] pidx;

    for (genvar g = 0; g < NCB; g++) begin : g_col
        assign cb[g] = col[8*g +: 8];
    end
    for (genvar g = 0; g < NPB; g++) begin : g_page
        assign pb[g] = page[8*g +: 8];
    end

    assign pidx = idx - ncol;

    // Pick the byte for the current address cycle
    always_comb begin
        abyte = 8'h00;
        for (int i = 0; i < NCB; i++)
            if (idx < ncol && idx == 3'(i)) abyte = cb[i];
        for (int j = 0; j < NPB; j++)
            if (idx >= ncol && pidx == 3'(j)) abyte = pb[j];
    end
endmodule

// File: rtl/nand_rb_timer.sv
// Counts clocks spent in the ready wait and flags expiry when the count
// reaches the programmed limit. Cleared whenever the wait is not running.
module nand_rb_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt;

    // Saturating wait counter
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (!run)     cnt <= '0;
        else if (cnt != '1) cnt <= cnt + 1'b1;
    end

    assign expired = run && (({1'b0, cnt} + 1'b1) >= {1'b0, limit});

    // R12
    tmr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
endmodule

// File: rtl/nand_cmd_seq.sv
// NAND command cycle sequencer. Accepts one request at a time (held by
// the host until req_ack), emits the opcode/address/closing-opcode bytes
// with a two-clock write strobe each, keeps a deferred closing opcode
// pending, and optionally waits for ready with a cycle limit.
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int COL_W      = 16,
    parameter int PAGE_W     = 24,
    parameter int PAGE_BYTES = 2048,
    parameter int TMO_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [7:0]        req_op,
    input  logic [COL_W-1:0]  req_col,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [TMO_W-1:0]  tmo_limit,
    output logic              req_ack,
    output logic              ack_err_unknown,
    output logic              ack_err_timeout,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic [7:0]        nand_io_out,
    output logic              nand_io_oe,
    input  logic              nand_rb
);
    seq_state_t        state;
    logic              ph;
    logic [2:0]        idx;
    nfmt_t             fmt, fmt_r;
    logic [COL_W-1:0]  col_eff, col_r;
    logic [PAGE_W-1:0] page_r;
    logic              pend_v;
    logic [7:0]        pend_op;
    logic              err_unk_r, err_to_r;
    logic              tmo;
    logic [7:0]        abyte;
    logic [2:0]        naddr;
    logic              absorb;
    seq_state_t        after_addr, after_cmd;

    nand_fmt_rom #(.COL_W(COL_W), .PAGE_BYTES(PAGE_BYTES)) i_rom (
        .op(req_op), .col(req_col), .fmt(fmt), .col_eff(col_eff));

    nand_addr_mux #(.COL_W(COL_W), .PAGE_W(PAGE_W)) i_amux (
        .idx(idx), .ncol(fmt_r.ncol), .col(col_r), .page(page_r), .abyte(abyte));

    nand_rb_timer #(.TMO_W(TMO_W)) i_tmr (
        .clk(clk), .rst_n(rst_n), .run(state == SQ_WAIT),
        .limit(tmo_limit), .expired(tmo));

    // Next-state choices after the address and after the last opcode
    always_comb begin
        naddr      = fmt_r.ncol + fmt_r.npage;
        absorb     = pend_v && (req_op == pend_op);
        after_cmd  = fmt_r.wait_rb ? SQ_WAIT : SQ_ACK;
        after_addr = (fmt_r.has2 && !fmt_r.defer) ? SQ_CMD2 : after_cmd;
    end

    // Sequencer state, captured request and pending closing opcode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            ph        <= 1'b0;
            idx       <= '0;
            fmt_r     <= '0;
            col_r     <= '0;
            page_r    <= '0;
            pend_v    <= 1'b0;
            pend_op   <= '0;
            err_unk_r <= 1'b0;
            err_to_r  <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    err_unk_r <= 1'b0;
                    err_to_r  <= 1'b0;
                    ph        <= 1'b0;
                    idx       <= '0;
                    if (req_valid) begin
                        fmt_r  <= fmt;
                        col_r  <= col_eff;
                        page_r <= req_page;
                        if (absorb) begin
                            pend_v <= 1'b0;
                            state  <= SQ_ACK;
                        end else if (!fmt.known) begin
                            err_unk_r <= 1'b1;
                            state     <= SQ_ACK;
                        end else begin
                            if (fmt.defer) begin
                                pend_v  <= 1'b1;
                                pend_op <= fmt.op2;
                            end
                            state <= SQ_CMD1;
                        end
                    end
                end
                SQ_CMD1: begin
                    ph <= ~ph;
                    if (ph) state <= (naddr != 3'd0) ? SQ_ADDR : after_addr;
                end
                SQ_ADDR: begin
                    ph <= ~ph;
                    if (ph) begin
                        if (idx == naddr - 3'd1) state <= after_addr;
                        else                     idx   <= idx + 3'd1;
                    end
                end
                SQ_CMD2: begin
                    ph <= ~ph;
                    if (ph) state <= after_cmd;
                end
                SQ_WAIT: begin
                    if (nand_rb) state <= SQ_ACK;
                    else if (tmo) begin
                        err_to_r <= 1'b1;
                        state    <= SQ_ACK;
                    end
                end
                SQ_ACK:  state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Bus pins and acknowledge decoded from sequencer state
    always_comb begin
        nand_cle        = (state == SQ_CMD1) || (state == SQ_CMD2);
        nand_ale        = (state == SQ_ADDR);
        nand_io_oe      = nand_cle || nand_ale;
        nand_we_n       = !(nand_io_oe && !ph);
        nand_io_out     = (state == SQ_CMD1) ? fmt_r.op1 :
                          (state == SQ_CMD2) ? fmt_r.op2 :
                          (state == SQ_ADDR) ? abyte : 8'h00;
        req_ack         = (state == SQ_ACK);
        ack_err_unknown = req_ack && err_unk_r;
        ack_err_timeout = req_ack && err_to_r;
    end

    // R2
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    // R2
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |=> (nand_we_n && $stable(nand_io_out) &&
                        $stable(nand_cle) && $stable(nand_ale)));
    // R11
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);
    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_WAIT && !nand_rb && !tmo) |=> (state == SQ_WAIT && !req_ack));
    // R9
    absorb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_IDLE && req_valid && absorb) |=>
            (req_ack && !pend_v && !nand_io_oe && !ack_err_unknown));
    // R10
    unknown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_IDLE && req_valid && !absorb && !fmt.known) |=>
            (req_ack && ack_err_unknown && !nand_io_oe));
endmodule

// File: tb/test_nand_cmd_seq.sv
module test_nand_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_op = 8'h00;
    logic [15:0] req_col = '0;
    logic [23:0] req_page = '0;
    logic [15:0] tmo_limit = 16'd1000;
    logic        req_ack, ack_err_unknown, ack_err_timeout;
    logic        nand_cle, nand_ale, nand_we_n, nand_io_oe;
    logic [7:0]  nand_io_out;
    logic        nand_rb = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    nand_cmd_seq i_nand_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_col(req_col), .req_page(req_page), .tmo_limit(tmo_limit),
        .req_ack(req_ack), .ack_err_unknown(ack_err_unknown),
        .ack_err_timeout(ack_err_timeout), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_io_out(nand_io_out),
        .nand_io_oe(nand_io_oe), .nand_rb(nand_rb));

    // Bus log: {cle, ale, byte} captured on each strobe rising edge
    logic [9:0] log_b [16];
    int         log_n = 0;
    logic       prev_we = 1'b1;
    int         wide_strobe = 0;

    always @(negedge clk) begin
        if (rst_n && !prev_we && nand_we_n && log_n < 16) begin
            log_b[log_n] = {nand_cle, nand_ale, nand_io_out};
            log_n++;
        end
        if (rst_n && !prev_we && !nand_we_n) wide_strobe++;
        prev_we = nand_we_n;
    end

    // Bench reference model
    logic [9:0] exp_b [16];
    int         exp_n;
    bit         exp_wait, exp_unk;
    bit         m_pend = 0;
    logic [7:0] m_pend_op = 8'h00;

    task automatic push_cmd(input logic [7:0] b);
        exp_b[exp_n] = {2'b10, b}; exp_n++;
    endtask
    task automatic push_adr(input logic [7:0] b);
        exp_b[exp_n] = {2'b01, b}; exp_n++;
    endtask

    // Expected bus bytes, wait and error for a request (R3..R10, R13)
    task automatic model(input logic [7:0] op, input logic [15:0] col,
                         input logic [23:0] pg);
        logic [15:0] c;
        exp_n = 0; exp_wait = 0; exp_unk = 0;
        if (m_pend && op == m_pend_op) begin
            m_pend = 0;
            return;
        end
        c = (op == 8'h50) ? col + 16'd2048 : col;
        case (op)
            8'h00, 8'h50, 8'h80: begin
                push_cmd((op == 8'h80) ? 8'h80 : 8'h00);
                push_adr(c[7:0]); push_adr(c[15:8]);
                push_adr(pg[7:0]); push_adr(pg[15:8]); push_adr(pg[23:16]);
                if (op == 8'h80) begin m_pend = 1; m_pend_op = 8'h10; end
                else begin push_cmd(8'h30); exp_wait = 1; end
            end
            8'h05: begin push_cmd(8'h05); push_adr(c[7:0]); push_adr(c[15:8]); push_cmd(8'hE0); end
            8'h85: begin push_cmd(8'h85); push_adr(c[7:0]); push_adr(c[15:8]); end
            8'h90, 8'hEC, 8'hEE, 8'hEF: begin
                push_cmd(op); push_adr(c[7:0]);
                exp_wait = (op == 8'hEC || op == 8'hEE);
            end
            8'h70: push_cmd(op);
            8'hFF: begin push_cmd(op); exp_wait = 1; end
            8'h60: begin push_cmd(op); push_adr(pg[7:0]); push_adr(pg[15:8]); push_adr(pg[23:16]); push_cmd(8'hD0); end
            default: exp_unk = 1;
        endcase
    endtask

    function automatic string tag_of(input logic [7:0] op);
        case (op)
            8'h00: return "R3";
            8'h05: return "R4";
            8'h90, 8'hEC, 8'hEE, 8'hEF: return "R5";
            8'h70, 8'hFF: return "R6";
            8'h60: return "R7";
            8'h80, 8'h85: return "R8";
            8'h50: return "R13";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Issue one request; rb_rel<0 keeps the device busy for good
    task automatic run_req(input logic [7:0] op, input logic [15:0] col,
                           input logic [23:0] pg, input int rb_rel,
                           input logic [15:0] lim);
        int   cyc = 0;
        bit   absorbed;
        bit   exp_to;
        string tg;
        absorbed = m_pend && (op == m_pend_op);
        model(op, col, pg);
        tg = absorbed ? "R9" : tag_of(op);
        exp_to = exp_wait && (rb_rel < 0);
        @(negedge clk);
        log_n = 0; wide_strobe = 0;
        tmo_limit = lim; nand_rb = 1'b0;
        req_op = op; req_col = col; req_page = pg; req_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (req_ack) break;
            cyc++;
            if (cyc == rb_rel) nand_rb = 1'b1;
        end
        // R11: acknowledge only after ready was sampled
        if (exp_wait && !exp_to)
            check(nand_rb == 1'b1, "R11", nand_rb, 1);
        check(ack_err_unknown == exp_unk, exp_unk ? "R10" : tg, ack_err_unknown, exp_unk);
        // R12
        check(ack_err_timeout == exp_to, "R12", ack_err_timeout, exp_to);
        check(log_n == exp_n, tg, log_n, exp_n);
        check(wide_strobe == 0, "R2", wide_strobe, 0);
        for (int k = 0; k < exp_n && k < log_n; k++)
            check(log_b[k] == exp_b[k], {"R2/", tg}, log_b[k], exp_b[k]);
        req_valid = 1'b0;
        nand_rb = 1'b1;
        @(negedge clk);
        // R11: single-cycle acknowledge
        check(req_ack == 1'b0, "R11", req_ack, 0);
    endtask

    logic [7:0] op_pool [13] = '{8'h00, 8'h05, 8'h90, 8'h70, 8'h80, 8'h85,
                                 8'h60, 8'hFF, 8'hEC, 8'hEE, 8'hEF, 8'h50, 8'h10};

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(nand_we_n && !nand_cle && !nand_ale && !nand_io_oe && !req_ack,
              "R1", {nand_we_n, nand_cle, nand_ale, nand_io_oe, req_ack}, 5'b10000);

        run_req(8'h00, 16'h1234, 24'hABCDEF, 40, 16'd1000);   // R3
        run_req(8'h05, 16'h0F0E, 24'h0, -1, 16'd1000);        // R4
        run_req(8'h90, 16'h0020, 24'h0, -1, 16'd1000);        // R5
        run_req(8'hEE, 16'h0001, 24'h0, 30, 16'd1000);        // R5
        run_req(8'h70, 16'h0, 24'h0, -1, 16'd1000);           // R6
        run_req(8'h60, 16'hFFFF, 24'h123456, -1, 16'd1000);   // R7
        run_req(8'h80, 16'h0102, 24'h030405, -1, 16'd1000);   // R8
        run_req(8'h70, 16'h0, 24'h0, -1, 16'd1000);           // R8 pending kept
        run_req(8'h10, 16'h0, 24'h0, -1, 16'd1000);           // R9 absorbed
        run_req(8'h10, 16'h0, 24'h0, -1, 16'd1000);           // R9 now unknown
        run_req(8'h3C, 16'h0, 24'h0, -1, 16'd1000);           // R10
        run_req(8'h50, 16'hF810, 24'h000777, 25, 16'd1000);   // R13
        run_req(8'hFF, 16'h0, 24'h0, -1, 16'd25);             // R12 timeout
        run_req(8'hEC, 16'h0, 24'h0, -1, 16'd1);              // R12 short limit

        for (int it = 0; it < 80; it++) begin
            logic [7:0] op;
            int rel;
            op  = op_pool[$urandom % 13];
            if ($urandom % 10 == 0) op = 8'($urandom);
            rel = ($urandom % 8 == 0) ? -1 : 5 + int'($urandom % 50);
            run_req(op, 16'($urandom), 24'($urandom), rel, 16'd200);
        end

        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(200_000 * 10);
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule